// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block turns a fixed peripheral clock into the two timing strobes a UART needs: an oversampling tick that runs at sixteen times the bit rate, and a bit-rate tick. The rate is set by a 16-bit integer divisor and by a fractional stage. The fractional stage stretches some divisor periods so that the long-run oversampling rate is `clk / (D * (1 + A/M))`, where D is the divisor, A is the fraction addend and M is the fraction modulus.

The block owns the small register window that configures it. A latch-select bit in the line settings register picks what two low offsets reach. When the bit is clear they reach the byte-buffer and interrupt-enable locations. When it is set they reach the two divisor bytes. Writes to the byte buffer are passed on as a one-cycle strobe carrying the byte for the transmitter. Reads of it return the receiver byte input. Transmit and receive shifting are not part of this block.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, reads return the following values: line settings 0x00, divisor low byte 0x01, divisor high byte 0x00, fraction register 0x10, interrupt enable 0x00. Read data appears on the cycle after the read address.
- R2: The register offsets are: line settings 0x0C, with the latch-select bit at bit 7; fraction register 0x28, with the addend A in bits 3:0 and the modulus M in bits 7:4. When latch-select is 1, offset 0x00 writes and reads the divisor low byte and offset 0x04 writes and reads the divisor high byte.
- R3: When latch-select is 0, a write to offset 0x00 leaves the divisor unchanged. Instead it raises a byte strobe for exactly one cycle after the write edge, together with the written byte. A read of offset 0x00 returns the receiver byte input. Offset 0x04 is the interrupt-enable byte.
- R4: When the fraction is bypassed, an oversample tick occurs every D cycles, where D = {high, low}. A divisor of 0 behaves as 1.
- R5: When 0 < A < M, each tick interval is either D or 2D cycles. An accumulator that starts at 0 adds A at every interval. When the sum reaches M, M is subtracted and that interval is 2D. With a 12 MHz clock, this gives the following bit periods: D=52, A=1, M=2 gives 1248 cycles (9600 baud); D=3, A=1, M=4 gives 60 cycles (200000 baud); D=5, A=3, M=10 gives 520 cycles over five bits (115200 baud).
- R6: A modulus of 0 behaves as 1. When A = 0 or A >= M, the fractional stage is bypassed.
- R7: The bit-rate tick is high only together with an oversample tick. After a restart it is high on the 16th oversample tick, and then on every 16th one after that.
- R8: A write to either divisor byte or to the fraction register restarts the counters. The first tick then appears D+1 cycles after the write edge. Writes to line settings or interrupt enable do not disturb the tick train.
- R9: With D > 1, the oversample tick is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 6 | Register write byte offset |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 6 | Register read byte offset |
| rx_byte_i | input | 8 | Receiver byte, returned on buffer reads |
| rd_data_o | output | 8 | Registered read data |
| tx_stb_o | output | 1 | One-cycle strobe on a byte-buffer write |
| tx_byte_o | output | 8 | Byte written to the buffer |
| os_tick_o | output | 1 | Oversample tick |
| bit_tick_o | output | 1 | Bit-rate tick |

## Verification
The tick train is measured with the fraction bypassed for three divisor values: 7, 0 (which behaves as 1), and 256, the last of which exercises the high byte. Each of these confirms the plain interval length. Three fractional settings from common baud rates are then applied. Their first intervals show whether the stretch lands on the correct period, and their bit periods show whether the average is exact. Degenerate fractions (M=0, and A equal to M) must reproduce the plain train. Writes through the shared offsets with the latch-select bit in both states show whether a byte reaches the divisor or the strobe. Writes of the line settings in the middle of a train show whether a restart was wrongly triggered.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
  localparam int OFS_BUF   = 'h00;
  localparam int OFS_IE    = 'h04;
  localparam int OFS_LINE  = 'h0C;
  localparam int OFS_FRAC  = 'h28;
  localparam int LSEL_BIT  = 7;
  localparam int FRAC_W    = 4;

  typedef struct packed {
    logic [FRAC_W-1:0] modulus;
    logic [FRAC_W-1:0] addend;
  } frac_cfg_t;

  function automatic logic [FRAC_W-1:0] eff_modulus(input logic [FRAC_W-1:0] m);
    return (m == '0) ? FRAC_W'(1) : m;
  endfunction
endpackage

// File: rtl/frac_baud_regs.sv
module frac_baud_regs
  import frac_baud_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DIV_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [7:0]        rx_byte_i,
  output logic [7:0]        rd_data_o,
  output logic [DIV_W-1:0]  div_o,
  output frac_cfg_t         frac_o,
  output logic              restart_o,
  output logic              tx_stb_o,
  output logic [7:0]        tx_byte_o
);
  localparam int HI_W = DIV_W - 8;

  logic [7:0]      line_q;
  logic [7:0]      ie_q;
  logic [7:0]      dl_lo_q;
  logic [HI_W-1:0] dl_hi_q;
  frac_cfg_t       frac_q;
  logic            lsel;
  logic            we_buf, we_ie, we_line, we_frac;
  logic            we_lo, we_hi, we_dbuf, we_ien;

  assign lsel    = line_q[LSEL_BIT];
  assign we_buf  = wr_en_i && (wr_addr_i == ADDR_W'(OFS_BUF));
  assign we_ie   = wr_en_i && (wr_addr_i == ADDR_W'(OFS_IE));
  assign we_line = wr_en_i && (wr_addr_i == ADDR_W'(OFS_LINE));
  assign we_frac = wr_en_i && (wr_addr_i == ADDR_W'(OFS_FRAC));
  assign we_lo   = we_buf && lsel;
  assign we_hi   = we_ie && lsel;
  assign we_dbuf = we_buf && !lsel;
  assign we_ien  = we_ie && !lsel;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      line_q    <= '0;
      ie_q      <= '0;
      dl_lo_q   <= 8'h01;
      dl_hi_q   <= '0;
      frac_q    <= '{modulus: FRAC_W'(1), addend: '0};
      restart_o <= 1'b1;
      tx_stb_o  <= 1'b0;
      tx_byte_o <= '0;
    end else begin
      if (we_line) line_q  <= wr_data_i;
      if (we_ien)  ie_q    <= wr_data_i;
      if (we_lo)   dl_lo_q <= wr_data_i;
      if (we_hi)   dl_hi_q <= wr_data_i[HI_W-1:0];
      if (we_frac) frac_q  <= frac_cfg_t'(wr_data_i);
      restart_o <= we_lo || we_hi || we_frac;
      tx_stb_o  <= we_dbuf;
      if (we_dbuf) tx_byte_o <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rd_data_o <= '0;
    end else begin
      if (rd_addr_i == ADDR_W'(OFS_BUF))
        rd_data_o <= lsel ? dl_lo_q : rx_byte_i;
      else if (rd_addr_i == ADDR_W'(OFS_IE))
        rd_data_o <= lsel ? 8'(dl_hi_q) : ie_q;
      else if (rd_addr_i == ADDR_W'(OFS_LINE))
        rd_data_o <= line_q;
      else if (rd_addr_i == ADDR_W'(OFS_FRAC))
        rd_data_o <= frac_q;
      else
        rd_data_o <= '0;
    end
  end

  assign div_o  = {dl_hi_q, dl_lo_q};
  assign frac_o = frac_q;

  AST_STB_LSEL_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
    tx_stb_o |-> !$past(lsel)); // R3
  AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(wr_en_i) |-> $stable(div_o)); // R3
endmodule

// File: rtl/frac_baud_frac.sv
module frac_baud_frac
  import frac_baud_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_i,
  input  logic      restart_i,
  input  frac_cfg_t cfg_i,
  input  logic      step_i,
  output logic      stretch_o
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;
  logic [FRAC_W-1:0] mod_eff;
  logic              frac_on;

  assign mod_eff   = eff_modulus(cfg_i.modulus);
  assign frac_on   = (cfg_i.addend != '0) && (cfg_i.addend < mod_eff);
  assign sum       = {1'b0, acc_q} + {1'b0, cfg_i.addend};
  assign stretch_o = frac_on && (sum >= {1'b0, mod_eff});

  always_ff @(posedge clk_i) begin
    if (rst_i || restart_i) begin
      acc_q <= '0;
    end else if (step_i) begin
      if (stretch_o)    acc_q <= FRAC_W'(sum - {1'b0, mod_eff});
      else if (frac_on) acc_q <= FRAC_W'(sum);
      else              acc_q <= '0;
    end
  end

  AST_ACC_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    (frac_on && !restart_i) |-> (acc_q < mod_eff)); // R5
endmodule

// File: rtl/frac_baud_presc.sv
module frac_baud_presc #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             stretch_i,
  output logic             step_o,
  output logic             tick_nxt_o,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_eff;
  logic             ext_q;
  logic             at_zero;

  assign div_eff    = (div_i == '0) ? DIV_W'(1) : div_i;
  assign at_zero    = (cnt_q == '0);
  assign step_o     = at_zero && !ext_q && !restart_i;
  assign tick_nxt_o = at_zero && !restart_i && (ext_q || !stretch_i);

  always_ff @(posedge clk_i) begin
    if (rst_i || restart_i) begin
      cnt_q  <= div_eff - DIV_W'(1);
      ext_q  <= 1'b0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= tick_nxt_o;
      if (at_zero) begin
        cnt_q <= div_eff - DIV_W'(1);
        ext_q <= ext_q ? 1'b0 : stretch_i;
      end else begin
        cnt_q <= cnt_q - DIV_W'(1);
      end
    end
  end

  AST_TICK_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_o && div_eff != DIV_W'(1)) |=> !tick_o); // R9
endmodule

// File: rtl/frac_baud_bitdiv.sv
module frac_baud_bitdiv #(
  parameter int OSR = 16
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic restart_i,
  input  logic tick_nxt_i,
  output logic bit_o
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || restart_i) begin
      cnt_q <= '0;
      bit_o <= 1'b0;
    end else begin
      bit_o <= tick_nxt_i && (cnt_q == LAST);
      if (tick_nxt_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import frac_baud_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DIV_W  = 16,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [7:0]        rx_byte_i,
  output logic [7:0]        rd_data_o,
  output logic              tx_stb_o,
  output logic [7:0]        tx_byte_o,
  output logic              os_tick_o,
  output logic              bit_tick_o
);
  logic [DIV_W-1:0] div;
  frac_cfg_t        frac;
  logic             restart, step, stretch, tick_nxt;

  frac_baud_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) regs_i (
    .clk_i, .rst_i, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rx_byte_i,
    .rd_data_o, .div_o(div), .frac_o(frac), .restart_o(restart),
    .tx_stb_o, .tx_byte_o
  );

  frac_baud_frac frac_i (
    .clk_i, .rst_i, .restart_i(restart), .cfg_i(frac),
    .step_i(step), .stretch_o(stretch)
  );

  frac_baud_presc #(.DIV_W(DIV_W)) presc_i (
    .clk_i, .rst_i, .restart_i(restart), .div_i(div), .stretch_i(stretch),
    .step_o(step), .tick_nxt_o(tick_nxt), .tick_o(os_tick_o)
  );

  frac_baud_bitdiv #(.OSR(OSR)) bitdiv_i (
    .clk_i, .rst_i, .restart_i(restart), .tick_nxt_i(tick_nxt),
    .bit_o(bit_tick_o)
  );

  AST_BIT_WITH_OS: assert property (@(posedge clk_i) disable iff (rst_i)
    bit_tick_o |-> os_tick_o); // R7
  AST_RESTART_SILENT: assert property (@(posedge clk_i) disable iff (rst_i)
    restart |=> !os_tick_o); // R8
endmodule

// File: tb/frac_baud_gen_tb_top.sv
module frac_baud_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [5:0] rd_addr = '0;
  logic [7:0] rx_byte = 8'h3C;
  logic [7:0] rd_data;
  logic       tx_stb, os_tick, bit_tick;
  logic [7:0] tx_byte;

  int cyc = 0, n_chk = 0, n_bad = 0, wr_cyc = 0;
  logic       stb_seen;
  logic [7:0] byte_seen;

  frac_baud_gen dut_i (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rx_byte_i(rx_byte),
    .rd_data_o(rd_data), .tx_stb_o(tx_stb), .tx_byte_o(tx_byte),
    .os_tick_o(os_tick), .bit_tick_o(bit_tick)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
    wr_cyc = cyc; stb_seen = tx_stb; byte_seen = tx_byte;
  endtask

  task automatic reg_rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a;
    @(posedge clk);
    @(negedge clk); d = rd_data;
  endtask

  task automatic wait_tick(output int t);
    do @(negedge clk); while (os_tick !== 1'b1);
    t = cyc;
  endtask

  task automatic wait_bit(output int t);
    do @(negedge clk); while (bit_tick !== 1'b1);
    t = cyc;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    reg_rd(6'h0C, d); chk(d == 8'h00, "R1 line", d, 0);
    reg_rd(6'h04, d); chk(d == 8'h00, "R1 ie", d, 0);
    reg_rd(6'h28, d); chk(d == 8'h10, "R1 frac", d, 'h10);
    reg_wr(6'h0C, 8'h80);
    reg_rd(6'h00, d); chk(d == 8'h01, "R1 dl low", d, 1);
    reg_rd(6'h04, d); chk(d == 8'h00, "R1 dl high", d, 0);
  endtask

  task automatic t_map();
    logic [7:0] d;
    reg_wr(6'h0C, 8'h80);
    reg_wr(6'h00, 8'h34);
    chk(stb_seen == 1'b0, "R2 no strobe when latch-select set", stb_seen, 0);
    reg_wr(6'h04, 8'h12);
    reg_wr(6'h28, 8'h52);
    reg_rd(6'h00, d); chk(d == 8'h34, "R2 dl low", d, 'h34);
    reg_rd(6'h04, d); chk(d == 8'h12, "R2 dl high", d, 'h12);
    reg_rd(6'h28, d); chk(d == 8'h52, "R2 frac", d, 'h52);
  endtask

  task automatic t_shared();
    logic [7:0] d;
    reg_wr(6'h0C, 8'h00);
    reg_wr(6'h00, 8'hA5);
    chk(stb_seen == 1'b1, "R3 strobe", stb_seen, 1);
    chk(byte_seen == 8'hA5, "R3 strobe byte", byte_seen, 'hA5);
    @(negedge clk); chk(tx_stb == 1'b0, "R3 strobe one cycle", tx_stb, 0);
    reg_wr(6'h04, 8'h0F);
    reg_rd(6'h04, d); chk(d == 8'h0F, "R3 ie", d, 'h0F);
    reg_rd(6'h00, d); chk(d == 8'h3C, "R3 rx byte", d, 'h3C);
    reg_wr(6'h0C, 8'h80);
    reg_rd(6'h00, d); chk(d == 8'h34, "R3 dl low kept", d, 'h34);
    reg_rd(6'h04, d); chk(d == 8'h12, "R3 dl high kept", d, 'h12);
  endtask

  task automatic t_integer();
    int t1, t2;
    reg_wr(6'h28, 8'h10); reg_wr(6'h04, 8'h00); reg_wr(6'h00, 8'd7);
    wait_tick(t1); chk(t1 - wr_cyc == 8, "R8 first tick", t1 - wr_cyc, 8);
    wait_tick(t2); chk(t2 - t1 == 7, "R4 div 7", t2 - t1, 7);
    @(negedge clk); chk(os_tick == 1'b0, "R9 single pulse", os_tick, 0);
    reg_wr(6'h00, 8'd0);
    wait_tick(t1); wait_tick(t2); chk(t2 - t1 == 1, "R4 div 0 as 1", t2 - t1, 1);
    reg_wr(6'h04, 8'd1);
    wait_tick(t1); wait_tick(t2); chk(t2 - t1 == 256, "R4 div 256", t2 - t1, 256);
  endtask

  task automatic t_no_restart();
    int t0, t1;
    reg_wr(6'h04, 8'd0); reg_wr(6'h00, 8'd7);
    wait_tick(t0); reg_wr(6'h0C, 8'h80);
    wait_tick(t1); chk(t1 - t0 == 7, "R8 line write keeps train", t1 - t0, 7);
    reg_wr(6'h0C, 8'h00); reg_wr(6'h04, 8'h03); reg_wr(6'h0C, 8'h80);
    wait_tick(t0); wait_tick(t1); chk(t1 - t0 == 7, "R8 ie write keeps divisor", t1 - t0, 7);
  endtask

  task automatic t_frac();
    int t1, t2, t3, b1, b2;
    reg_wr(6'h04, 8'd0); reg_wr(6'h28, 8'h21); reg_wr(6'h00, 8'd52);
    wait_tick(t1); chk(t1 - wr_cyc == 53, "R5 9600 first", t1 - wr_cyc, 53);
    wait_tick(t2); chk(t2 - t1 == 104, "R5 9600 stretched", t2 - t1, 104);
    wait_tick(t3); chk(t3 - t2 == 52, "R5 9600 plain", t3 - t2, 52);
    wait_bit(b1); wait_bit(b2); chk(b2 - b1 == 1248, "R5 9600 bit", b2 - b1, 1248);
    reg_wr(6'h28, 8'h41); reg_wr(6'h00, 8'd3);
    wait_bit(b1); wait_bit(b2); chk(b2 - b1 == 60, "R5 200000 bit", b2 - b1, 60);
    reg_wr(6'h28, 8'hA3); reg_wr(6'h00, 8'd5);
    wait_bit(b1);
    for (int i = 0; i < 5; i++) wait_bit(b2);
    chk(b2 - b1 == 520, "R5 115200 five bits", b2 - b1, 520);
  endtask

  task automatic t_bypass();
    int t1, t2;
    reg_wr(6'h28, 8'h01); reg_wr(6'h00, 8'd3);
    wait_tick(t1);
    for (int i = 0; i < 4; i++) begin
      wait_tick(t2); chk(t2 - t1 == 3, "R6 modulus 0", t2 - t1, 3); t1 = t2;
    end
    reg_wr(6'h28, 8'h33);
    wait_tick(t1);
    for (int i = 0; i < 4; i++) begin
      wait_tick(t2); chk(t2 - t1 == 3, "R6 addend equals modulus", t2 - t1, 3); t1 = t2;
    end
  endtask

  task automatic t_bit_align();
    int n = 0, at = 0, stray = 0;
    reg_wr(6'h28, 8'h10); reg_wr(6'h00, 8'd2);
    for (int i = 0; i < 200 && at == 0; i++) begin
      @(negedge clk);
      if (bit_tick && !os_tick) stray++;
      if (os_tick) n++;
      if (bit_tick) at = n;
    end
    chk(at == 16, "R7 bit on 16th tick", at, 16);
    chk(stray == 0, "R7 bit only with tick", stray, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_map();
    t_shared();
    t_integer();
    t_no_restart();
    t_frac();
    t_bypass();
    t_bit_align();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule